// File: doc/BRIEF.md
# Serial-Addressed Successive-Approximation Sequencer

This block is the digital control core of an 8-bit successive-approximation converter that a host drives over a serial link. While the active-low select input is held low, the block watches the serial input on rising clock edges for a start bit. It then shifts in a short assignment word that chooses the input configuration, drives one-hot enables for the positive and negative legs of an external analog multiplexer, and steps a trial code through one settling period and one approximation period per result bit, using a one-bit decision from an external comparator.

The result leaves on a serial output with a separate output-enable, so a pad or a shared data line can be tri-stated. The output changes on falling clock edges. After one leading low it sends the result most significant bit first and then again least significant bit first, with the LSB sent once and shared by both streams. In the 8-channel build a hold input can keep the LSB on the line for as long as it stays high. A busy output is high while the approximation runs. Raising the select input abandons any transfer at once, and each conversion needs a new select cycle.

Top module: `sar_serial_seq`

## Requirements
- R1: While cs_ni is high, dout_oe_o is low in the same cycle. At the next rising edge every internal register returns to its idle value: busy_o low, trial_o zero, all channel enables low. A new conversion then needs cs_ni low and a new start bit.
- R2: After cs_ni falls, low bits on din_i are ignored. The first high bit sampled is the start bit, and exactly CW+1 further bits (CW = log2 of NCH) form the assignment word, sent first bit first.
- R3: busy_o rises at the rising edge that samples the last assignment bit. It stays high for exactly RES+1 clock periods: one settling period and RES approximation periods.
- R4: din_i has no effect from the last assignment bit until the next select cycle. Toggling it changes neither the result stream nor the channel enables.
- R5: dout_oe_o first goes high one period after busy_o rises. The first driven period carries a low, and the next RES periods carry the result bits MSB first.
- R6: The trial code follows the successive-approximation step. Each step sets the current bit, keeps it when cmp_i is high (input at or above the trial level) and clears it otherwise. A comparator that reports the input at or above every trial gives all ones, and one that never does gives all zeros.
- R7: The assignment word is, in order: mode bit (1 = single-ended), odd/sign bit, then the select bits from high to low. The selected channel index is {select bits, odd/sign}. In single-ended mode ch_pos_o is one-hot at that index, ch_neg_o is zero and neg_ref_o is high (ground or the common terminal is the negative leg).
- R8: In differential mode ch_pos_o is one-hot at index {select, odd/sign}, ch_neg_o is one-hot at the other member of the same even/odd pair, and neg_ref_o is low.
- R9: After the MSB-first stream, with hold_lsb_i low, result bits 1 to RES-1 follow in ascending order on consecutive periods. The LSB is not repeated.
- R10: In the 8-channel build, each rising edge after the last approximation that samples hold_lsb_i high keeps the LSB on dout_o for one more period. The LSB-first bits follow once it is low.
- R11: After the last LSB-first bit, dout_oe_o goes low and the block stays idle with busy_o low, whatever happens on din_i, until cs_ni is cycled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Select, active low; high clears the block |
| din_i | input | 1 | Serial start bit and assignment word |
| hold_lsb_i | input | 1 | Keep the LSB on the output (8-channel build) |
| cmp_i | input | 1 | Comparator decision, high when input is at or above the trial level |
| trial_o | output | RES | Trial code for the external ladder; holds the result at the end |
| busy_o | output | 1 | Approximation in progress |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Enable for the serial output driver |
| ch_pos_o | output | NCH | One-hot positive-leg channel enable |
| ch_neg_o | output | NCH | One-hot negative-leg channel enable (differential mode) |
| neg_ref_o | output | 1 | Negative leg taken from ground or the common terminal |

## Verification
The bench builds the block with NCH = 8 and RES = 8. At that size the assignment word has four bits, the common-terminal negative leg is used, and the LSB hold mode is built in. All eight channels in both modes and both pair polarities are reachable, along with every 8-bit result value from a bench-side analog level. Random levels and words run alongside directed cases: full-scale and zero results, a mid-conversion select abort, serial-input noise during conversion, and several hold lengths.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETTLE,
    ST_CONV,
    ST_LSB,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/sar_seq_core.sv
module sar_seq_core #(
  parameter int RES = 8,
  localparam int IW = $clog2(RES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           start_i,
  input  logic           step_i,
  input  logic           cmp_i,
  output logic [RES-1:0] trial_o,
  output logic           last_o
);
  logic [RES-1:0] trial_q;
  logic [IW-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q <= '0;
      idx_q   <= '0;
    end else if (clr_i) begin
      trial_q <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      trial_q <= {1'b1, {(RES-1){1'b0}}};
      idx_q   <= IW'(RES-1);
    end else if (step_i) begin
      trial_q[idx_q] <= cmp_i;
      if (idx_q != '0) begin
        trial_q[idx_q - 1'b1] <= 1'b1;
        idx_q <= idx_q - 1'b1;
      end
    end
  end

  assign trial_o = trial_q;
  assign last_o  = (idx_q == '0);
endmodule

// File: rtl/sar_seq_mux.sv
module sar_seq_mux #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 1
) (
  input  logic          vld_i,
  input  logic [AW-1:0] word_i,
  output logic [NCH-1:0] pos_o,
  output logic [NCH-1:0] neg_o,
  output logic          ref_o
);
  logic          sgl;
  logic [CW-1:0] chan;

  // index = {select bits, odd/sign}
  assign sgl  = word_i[AW-1];
  assign chan = {word_i[AW-3:0], word_i[AW-2]};

  always_comb begin
    pos_o = '0;
    neg_o = '0;
    ref_o = 1'b0;
    if (vld_i) begin
      pos_o = NCH'(1) << chan;
      if (sgl) ref_o = 1'b1;
      else     neg_o = NCH'(1) << (chan ^ CW'(1));
    end
  end
endmodule

// File: rtl/sar_seq_tx.sv
module sar_seq_tx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic dout_o,
  output logic oe_o
);
  logic en_q, bit_q;

  // launch on falling edge: half a period of setup for a rising-edge host
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      bit_q <= 1'b0;
    end else if (cs_ni) begin
      en_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      en_q  <= en_i;
      bit_q <= bit_i;
    end
  end

  assign oe_o   = en_q & ~cs_ni;
  assign dout_o = oe_o & bit_q;
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RES = 8,
  localparam int CW  = $clog2(NCH),
  localparam int AW  = CW + 1,
  localparam int CNW = $clog2(AW + 1),
  localparam int IW  = $clog2(RES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           din_i,
  input  logic           hold_lsb_i,
  input  logic           cmp_i,
  output logic [RES-1:0] trial_o,
  output logic           busy_o,
  output logic           dout_o,
  output logic           dout_oe_o,
  output logic [NCH-1:0] ch_pos_o,
  output logic [NCH-1:0] ch_neg_o,
  output logic           neg_ref_o
);
  seq_state_e     state_q;
  logic [CNW-1:0] cnt_q;
  logic [AW-1:0]  word_q;
  logic           busy_q, vld_q, tx_en_q, tx_bit_q;
  logic [IW-1:0]  lsb_idx_q;
  logic           hold_eff, core_last;
  logic [RES-1:0] trial;

  generate
    if (NCH >= 8) begin : g_hold
      assign hold_eff = hold_lsb_i;
    end else begin : g_nohold
      assign hold_eff = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      word_q    <= '0;
      busy_q    <= 1'b0;
      vld_q     <= 1'b0;
      tx_en_q   <= 1'b0;
      tx_bit_q  <= 1'b0;
      lsb_idx_q <= '0;
    end else if (cs_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      word_q    <= '0;
      busy_q    <= 1'b0;
      vld_q     <= 1'b0;
      tx_en_q   <= 1'b0;
      tx_bit_q  <= 1'b0;
      lsb_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (din_i) begin
          state_q <= ST_ADDR;
          cnt_q   <= '0;
        end
        ST_ADDR: begin
          word_q <= {word_q[AW-2:0], din_i};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNW'(AW-1)) begin
            state_q <= ST_SETTLE;
            busy_q  <= 1'b1;
            vld_q   <= 1'b1;
          end
        end
        ST_SETTLE: begin
          state_q  <= ST_CONV;
          tx_en_q  <= 1'b1;
          tx_bit_q <= 1'b0;
        end
        ST_CONV: begin
          tx_bit_q <= cmp_i;
          if (core_last) begin
            state_q   <= ST_LSB;
            busy_q    <= 1'b0;
            lsb_idx_q <= IW'(1);
          end
        end
        ST_LSB: if (!hold_eff) begin
          tx_bit_q <= trial[lsb_idx_q];
          if (lsb_idx_q == IW'(RES-1)) state_q <= ST_DONE;
          else lsb_idx_q <= lsb_idx_q + 1'b1;
        end
        ST_DONE: tx_en_q <= 1'b0;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sar_seq_core #(.RES(RES)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cs_ni),
    .start_i (state_q == ST_SETTLE),
    .step_i  (state_q == ST_CONV),
    .cmp_i   (cmp_i),
    .trial_o (trial),
    .last_o  (core_last)
  );

  sar_seq_mux #(.NCH(NCH)) u_mux (
    .vld_i  (vld_q),
    .word_i (word_q),
    .pos_o  (ch_pos_o),
    .neg_o  (ch_neg_o),
    .ref_o  (neg_ref_o)
  );

  sar_seq_tx u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .en_i   (tx_en_q),
    .bit_i  (tx_bit_q),
    .dout_o (dout_o),
    .oe_o   (dout_oe_o)
  );

  assign trial_o = trial;
  assign busy_o  = busy_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NCH = 8,
  parameter int RES = 8,
  localparam int BW = $clog2(RES + 3)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cs_ni,
  input logic [RES-1:0] trial_o,
  input logic           busy_o,
  input logic [NCH-1:0] ch_pos_o,
  input logic [NCH-1:0] ch_neg_o
);
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run <= '0;
    else if (busy_o && busy_run != '1) busy_run <= busy_run + 1'b1;
    else if (!busy_o) busy_run <= '0;
  end

  p_deselect_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> !busy_o && ch_pos_o == '0);

  p_busy_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_run < BW'(RES + 1));

  p_mux_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    busy_o && $past(busy_o) |-> $stable(ch_pos_o) && $stable(ch_neg_o));

  p_result_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    !busy_o && !$past(busy_o) |-> $stable(trial_o));

  p_pos_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $countones(ch_pos_o) == 1);

  p_neg_onehot0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_neg_o));
endmodule

bind sar_serial_seq sar_seq_chk #(.NCH(NCH), .RES(RES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .trial_o  (trial_o),
  .busy_o   (busy_o),
  .ch_pos_o (ch_pos_o),
  .ch_neg_o (ch_neg_o)
);

// File: tb/sim_sar_serial_seq.sv
`timescale 1ns/1ps
module sim_sar_serial_seq;
  localparam int NCH = 8;
  localparam int RES = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, cs_ni = 1'b1, din = 1'b0, hold = 1'b0, cmp;
  logic [RES-1:0] trial;
  logic busy, dout, dout_oe, neg_ref;
  logic [NCH-1:0] ch_pos, ch_neg;
  logic [7:0] vin = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign cmp = (vin >= trial);

  sar_serial_seq #(.NCH(NCH), .RES(RES)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .din_i(din), .hold_lsb_i(hold),
    .cmp_i(cmp), .trial_o(trial), .busy_o(busy), .dout_o(dout), .dout_oe_o(dout_oe),
    .ch_pos_o(ch_pos), .ch_neg_o(ch_neg), .neg_ref_o(neg_ref));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_pos(input logic [3:0] w);
    return 1 << {w[1], w[0], w[2]};
  endfunction
  function automatic int exp_neg(input logic [3:0] w);
    return w[3] ? 0 : 1 << ({w[1], w[0], w[2]} ^ 3'd1);
  endfunction

  task automatic send_word(input logic [3:0] w, input int lead);
    cs_ni = 1'b1; din = 1'b0; hold = 1'b0;
    tick(); tick();
    cs_ni = 1'b0;
    for (int i = 0; i < lead; i++) tick();
    chk(busy == 1'b0 && dout_oe == 1'b0, "R2 zeros ignored", busy, 0);
    din = 1'b1; tick();
    for (int i = 3; i >= 0; i--) begin din = w[i]; tick(); end
  endtask

  task automatic run_conv(input logic [3:0] w, input logic [7:0] v, input int lead,
                          input int h, input bit noisy);
    logic rb[0:47], ro[0:47], rd[0:47];
    logic [7:0] msb;
    int bad;
    vin = v;
    send_word(w, lead);
    chk(ch_pos == NCH'(exp_pos(w)), w[3] ? "R7 pos" : "R8 pos", ch_pos, exp_pos(w));
    chk(ch_neg == NCH'(exp_neg(w)) && neg_ref == w[3], w[3] ? "R7 neg" : "R8 neg",
        {neg_ref, ch_neg}, {w[3], exp_neg(w)[7:0]});
    for (int k = 0; k <= 20 + h; k++) begin
      rb[k] = busy; ro[k] = dout_oe; rd[k] = dout;
      hold = (k >= 9 && k < 9 + h);
      din = (k >= 18 + h) ? 1'b1 : (noisy ? 1'($urandom) : 1'b0);
      tick();
      if (k == 12 && noisy)
        chk(ch_pos == NCH'(exp_pos(w)), "R4 mux", ch_pos, exp_pos(w));
    end
    bad = 0;
    for (int k = 0; k <= 20 + h; k++) if (rb[k] != (k <= 8)) bad++;
    chk(bad == 0, "R3 busy window", bad, 0);
    chk(ro[0] == 0 && ro[1] == 0 && ro[2] == 1 && rd[2] == 0, "R5 leading low",
        {ro[0], ro[1], ro[2], rd[2]}, 4'b0010);
    msb = '0; bad = 0;
    for (int k = 3; k <= 10; k++) begin msb = {msb[6:0], rd[k]}; if (!ro[k]) bad++; end
    chk(msb == v && bad == 0, noisy ? "R4 result" : "R5 R6 msb first", msb, v);
    bad = 0;
    for (int k = 11; k <= 10 + h; k++) if (!ro[k] || rd[k] != v[0]) bad++;
    if (h > 0) chk(bad == 0, "R10 hold lsb", bad, 0);
    msb = '0; msb[0] = rd[10];
    for (int j = 1; j < 8; j++) msb[j] = rd[10 + h + j];
    chk(msb == v, "R9 lsb first", msb, v);
    bad = 0;
    for (int k = 18 + h; k <= 20 + h; k++) if (ro[k] || rb[k]) bad++;
    chk(bad == 0 && trial == v, "R11 idle after stream", trial, v);
    din = 1'b0; hold = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5a17));
    tick(); tick();
    chk(busy == 0 && dout_oe == 0 && trial == 0 && ch_pos == 0, "R1 reset", busy, 0);
    rst_ni = 1'b1;
    tick();
    // directed
    run_conv(4'b1000, 8'hff, 0, 0, 0);
    run_conv(4'b0100, 8'h00, 2, 0, 0);
    run_conv(4'b0011, 8'h81, 1, 3, 0);
    run_conv(4'b1111, 8'h5a, 0, 1, 1);
    // abort mid-conversion
    vin = 8'h3c;
    send_word(4'b1010, 0);
    tick(); tick(); tick();
    cs_ni = 1'b1; #1;
    chk(dout_oe == 0, "R1 oe off", dout_oe, 0);
    tick();
    chk(busy == 0 && ch_pos == 0 && trial == 0, "R1 clear", {busy, trial}, 0);
    cs_ni = 1'b0; din = 1'b0;
    for (int i = 0; i < 6; i++) tick();
    chk(busy == 0 && dout_oe == 0, "R1 needs new start", busy, 0);
    // random
    for (int n = 0; n < 40; n++)
      run_conv(4'($urandom), 8'($urandom), int'($urandom % 4), int'($urandom % 4),
               1'($urandom));
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule